// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer with Hardware Page-Table Walk

This block translates virtual page numbers into physical frame numbers for one requester. It keeps a small, fully associative set of recent translations. Each stored translation carries the identifier of the address space that owns it, so translations of different processes can be held side by side and a process switch needs no flush. A lookup that finds a stored translation answers one cycle after it is accepted and makes no memory traffic.

When a lookup misses, a built-in walker reads a two-level page table through a request/response memory port. The first read takes its address from the root base input and the upper part of the page number. The second read takes its address from the table base found in the first entry and the lower part of the page number. Bit 0 of each table entry marks it as present. If both entries are present, the walker stores the translation and returns the frame number as an ordinary result, with no fault. If either entry is absent, the walker raises a page fault and stores nothing.

Software or the requester can remove a single translation, named by page number and address-space identifier, or clear all translations. Removals that arrive while a walk is in progress are held and applied when the walk finishes. A walk whose page matches a held removal does not store its translation.

Walker states: `WK_IDLE` (waiting for a miss), `WK_L1_REQ` (first-level read requested), `WK_L1_RSP` (waiting for first-level data), `WK_L2_REQ` (second-level read requested), `WK_L2_RSP` (waiting for second-level data). Transitions: IDLE→L1_REQ on an accepted miss. L1_REQ→L1_RSP and L2_REQ→L2_RSP when the memory port accepts the request. L1_RSP→L2_REQ on present first-level data. L1_RSP→IDLE on absent first-level data (fault). L2_RSP→IDLE on any second-level data (fill or fault).

Top module: `xlate_cache`

## Requirements
- R1: A lookup that matches a stored translation is accepted while `lk_ready` is high. One cycle later it gives `rs_valid`=1, `rs_hit`=1, `rs_fault`=0 and the stored frame number, and it issues no memory request.
- R2: A stored translation matches only when both the page number and the address-space identifier equal those of the lookup. The same page under another identifier misses and is stored in its own slot, and the first translation stays.
- R3: On a miss the walker first reads `root_base + 4*vpn[19:10]`. If bit 0 of that word is 1, it then reads `{word[31:12],12'h000} + 4*vpn[9:0]`. Each request holds `mem_req_valid` and its address steady until `mem_req_ready` is high.
- R4: If bit 0 of the second-level word is 1, the result has `rs_hit`=0, `rs_fault`=0 and frame number `word[31:12]`. The translation is stored, so the next identical lookup hits.
- R5: If bit 0 of the first-level or second-level word is 0, the result has `rs_fault`=1 and `rs_hit`=0, and nothing is stored, so a repeat of the lookup walks and faults again.
- R6: `lk_ready` is low for the whole of a walk and in any cycle where `inv_valid` is high.
- R7: An invalidate with `inv_all`=1 clears every stored translation.
- R8: An invalidate with `inv_all`=0 clears only the translation whose page number and identifier both equal `inv_vpn` and `inv_asid`.
- R9: An invalidate that arrives during a walk is applied when the walk ends. The walk still returns its result, but it stores nothing if the held invalidate names its page or is a clear-all. Two invalidates during one walk combine into a clear-all.
- R10: A new translation goes into the lowest-numbered empty slot. When all slots are full, slots are replaced in rotation starting at slot 0, and the rotation advances only on replacements into a full buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| root_base | input | 32 | Byte address of the first-level page table |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Lookup can be accepted this cycle |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_asid | input | 8 | Address-space identifier of the lookup |
| rs_valid | output | 1 | Result present (one cycle) |
| rs_pfn | output | 20 | Physical frame number of the result |
| rs_fault | output | 1 | Result is a page fault |
| rs_hit | output | 1 | Result came from a stored translation |
| inv_valid | input | 1 | Invalidate request |
| inv_all | input | 1 | Invalidate clears every translation |
| inv_vpn | input | 20 | Page number of a single invalidate |
| inv_asid | input | 8 | Identifier of a single invalidate |
| mem_req_valid | output | 1 | Page-table read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the page-table word |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Page-table word |

## Verification
The assertions assume that the memory returns exactly one response for each accepted request, and never a response with no request outstanding. They also assume that the same page and identifier are never stored twice, which holds because a translation is stored only after a miss. The bench memory model always accepts requests and answers each one in the cycle after acceptance, computing the word from the address alone. The bench issues lookups only after the previous result has come back, and invalidates only between lookups or during a walk.

// File: rtl/xl_pkg.sv
package xl_pkg;
    typedef enum logic [2:0] {
        WK_IDLE,
        WK_L1_REQ,
        WK_L1_RSP,
        WK_L2_REQ,
        WK_L2_RSP
    } wk_state_e;
endpackage

// File: rtl/xl_tlb_array.sv
module xl_tlb_array #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int ASID_W  = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VPN_W-1:0]   look_vpn,
    input  logic [ASID_W-1:0]  look_asid,
    output logic [ENTRIES-1:0] hit_vec,
    output logic [PFN_W-1:0]   hit_pfn,
    input  logic               fill_en,
    input  logic [VPN_W-1:0]   fill_vpn,
    input  logic [ASID_W-1:0]  fill_asid,
    input  logic [PFN_W-1:0]   fill_pfn,
    input  logic               inv_en,
    input  logic               inv_all,
    input  logic [VPN_W-1:0]   inv_vpn,
    input  logic [ASID_W-1:0]  inv_asid
);
    logic [ENTRIES-1:0] slot_v;
    logic [VPN_W-1:0]   slot_vpn  [ENTRIES];
    logic [ASID_W-1:0]  slot_asid [ENTRIES];
    logic [PFN_W-1:0]   slot_pfn  [ENTRIES];
    logic [ENTRIES-1:0] kill_vec;
    logic [IDX_W-1:0]   rr_ptr;
    logic [IDX_W-1:0]   victim;
    logic               free_found;

    // Per-slot match logic for lookup and for invalidate.
    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_match
        assign hit_vec[gi]  = slot_v[gi] && (slot_vpn[gi] == look_vpn)
                              && (slot_asid[gi] == look_asid);
        assign kill_vec[gi] = inv_en && slot_v[gi] && (inv_all ||
                              ((slot_vpn[gi] == inv_vpn) && (slot_asid[gi] == inv_asid)));
    end

    always_comb begin
        hit_pfn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) hit_pfn = hit_pfn | slot_pfn[i];
        end
    end

    // Lowest empty slot first, rotation pointer when full.
    always_comb begin
        free_found = 1'b0;
        victim     = rr_ptr;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!slot_v[i] && !free_found) begin
                victim     = IDX_W'(i);
                free_found = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_v <= '0;
            rr_ptr <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (fill_en && (victim == IDX_W'(i))) slot_v[i] <= 1'b1;
                else if (kill_vec[i])                  slot_v[i] <= 1'b0;
            end
            if (fill_en && !free_found) begin
                rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (fill_en && (victim == IDX_W'(i))) begin
                slot_vpn[i]  <= fill_vpn;
                slot_asid[i] <= fill_asid;
                slot_pfn[i]  <= fill_pfn;
            end
        end
    end
endmodule

// File: rtl/xl_walker.sv
module xl_walker
    import xl_pkg::*;
#(
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int ASID_W  = 8,
    parameter int ADDR_W  = 32,
    parameter int L1_BITS = 10,
    localparam int L2_BITS    = VPN_W - L1_BITS,
    localparam int PAGE_SHIFT = ADDR_W - PFN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VPN_W-1:0]  start_vpn,
    input  logic [ASID_W-1:0] start_asid,
    input  logic [ADDR_W-1:0] root_base,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              busy,
    output logic              done,
    output logic              done_fault,
    output logic [PFN_W-1:0]  done_pfn,
    output logic [VPN_W-1:0]  walk_vpn,
    output logic [ASID_W-1:0] walk_asid
);
    wk_state_e         state, nxt;
    logic [ADDR_W-1:0] l2_base;
    logic              pte_flags_unused;

    assign pte_flags_unused = ^mem_rsp_data[PAGE_SHIFT-1:1];

    always_comb begin
        nxt = state;
        unique case (state)
            WK_IDLE:   if (start)         nxt = WK_L1_REQ;
            WK_L1_REQ: if (mem_req_ready) nxt = WK_L1_RSP;
            WK_L1_RSP: if (mem_rsp_valid) nxt = mem_rsp_data[0] ? WK_L2_REQ : WK_IDLE;
            WK_L2_REQ: if (mem_req_ready) nxt = WK_L2_RSP;
            WK_L2_RSP: if (mem_rsp_valid) nxt = WK_IDLE;
            default:                      nxt = WK_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WK_IDLE;
        else        state <= nxt;
    end

    // Walk context registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_vpn  <= '0;
            walk_asid <= '0;
            l2_base   <= '0;
        end else begin
            if ((state == WK_IDLE) && start) begin
                walk_vpn  <= start_vpn;
                walk_asid <= start_asid;
            end
            if ((state == WK_L1_RSP) && mem_rsp_valid) begin
                l2_base <= {mem_rsp_data[ADDR_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
            end
        end
    end

    // Outputs.
    always_comb begin
        busy          = (state != WK_IDLE);
        mem_req_valid = (state == WK_L1_REQ) || (state == WK_L2_REQ);
        if (state == WK_L2_REQ)
            mem_req_addr = l2_base + ADDR_W'({walk_vpn[L2_BITS-1:0], 2'b00});
        else
            mem_req_addr = root_base + ADDR_W'({walk_vpn[VPN_W-1 -: L1_BITS], 2'b00});
        done       = mem_rsp_valid && (((state == WK_L1_RSP) && !mem_rsp_data[0])
                                       || (state == WK_L2_RSP));
        done_fault = !mem_rsp_data[0];
        done_pfn   = mem_rsp_data[ADDR_W-1 -: PFN_W];
    end
endmodule

// File: rtl/xlate_cache.sv
module xlate_cache #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int ASID_W  = 8,
    parameter int ADDR_W  = 32,
    parameter int L1_BITS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] root_base,
    input  logic              lk_valid,
    output logic              lk_ready,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              rs_valid,
    output logic [PFN_W-1:0]  rs_pfn,
    output logic              rs_fault,
    output logic              rs_hit,
    input  logic              inv_valid,
    input  logic              inv_all,
    input  logic [VPN_W-1:0]  inv_vpn,
    input  logic [ASID_W-1:0] inv_asid,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data
);
    logic [ENTRIES-1:0] hit_vec;
    logic [PFN_W-1:0]   hit_pfn;
    logic               hit, accept, start;
    logic               busy, walk_done, walk_fault;
    logic [PFN_W-1:0]   walk_pfn;
    logic [VPN_W-1:0]   walk_vpn;
    logic [ASID_W-1:0]  walk_asid;
    logic               pend_v, pend_all;
    logic [VPN_W-1:0]   pend_vpn;
    logic [ASID_W-1:0]  pend_asid;
    logic               eff_v, eff_all, apply_inv, kill_fill, fill_en;
    logic [VPN_W-1:0]   eff_vpn;
    logic [ASID_W-1:0]  eff_asid;

    assign hit      = |hit_vec;
    assign lk_ready = !busy && !inv_valid;
    assign accept   = lk_valid && lk_ready;
    assign start    = accept && !hit;

    // Held invalidate merged with an incoming one; two become a clear-all.
    assign eff_v     = pend_v || inv_valid;
    assign eff_all   = (pend_v && inv_valid) || (pend_v ? pend_all : inv_all);
    assign eff_vpn   = pend_v ? pend_vpn  : inv_vpn;
    assign eff_asid  = pend_v ? pend_asid : inv_asid;
    assign apply_inv = eff_v && (!busy || walk_done);
    assign kill_fill = eff_v && (eff_all || ((eff_vpn == walk_vpn) && (eff_asid == walk_asid)));
    assign fill_en   = walk_done && !walk_fault && !kill_fill;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_all  <= 1'b0;
            pend_vpn  <= '0;
            pend_asid <= '0;
        end else if (apply_inv) begin
            pend_v <= 1'b0;
        end else if (eff_v) begin
            pend_v    <= 1'b1;
            pend_all  <= eff_all;
            pend_vpn  <= eff_vpn;
            pend_asid <= eff_asid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_valid <= 1'b0;
            rs_pfn   <= '0;
            rs_fault <= 1'b0;
            rs_hit   <= 1'b0;
        end else begin
            rs_valid <= (accept && hit) || walk_done;
            rs_pfn   <= (accept && hit) ? hit_pfn : walk_pfn;
            rs_fault <= walk_done && walk_fault;
            rs_hit   <= accept && hit;
        end
    end

    xl_tlb_array #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)
    ) u_array (
        .clk(clk), .rst_n(rst_n),
        .look_vpn(lk_vpn), .look_asid(lk_asid),
        .hit_vec(hit_vec), .hit_pfn(hit_pfn),
        .fill_en(fill_en), .fill_vpn(walk_vpn), .fill_asid(walk_asid), .fill_pfn(walk_pfn),
        .inv_en(apply_inv), .inv_all(eff_all), .inv_vpn(eff_vpn), .inv_asid(eff_asid)
    );

    xl_walker #(
        .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W), .ADDR_W(ADDR_W), .L1_BITS(L1_BITS)
    ) u_walker (
        .clk(clk), .rst_n(rst_n),
        .start(start), .start_vpn(lk_vpn), .start_asid(lk_asid), .root_base(root_base),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .busy(busy), .done(walk_done), .done_fault(walk_fault), .done_pfn(walk_pfn),
        .walk_vpn(walk_vpn), .walk_asid(walk_asid)
    );
endmodule

// File: rtl/xl_tlb_checker.sv
module xl_tlb_checker #(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic               lk_ready,
    input logic               rs_valid,
    input logic               rs_fault,
    input logic               rs_hit,
    input logic               mem_req_valid,
    input logic               mem_req_ready,
    input logic [ADDR_W-1:0]  mem_req_addr,
    input logic [ENTRIES-1:0] hit_vec,
    input logic               fill_en,
    input logic               apply_inv,
    input logic               eff_all
);
    assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && lk_ready |=> rs_valid || mem_req_valid);

    assert_unique_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    assert_fault_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rs_fault |-> rs_valid && !rs_hit);

    assert_fault_nofill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rs_valid && rs_fault |-> $past(!fill_en));

    assert_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !lk_ready);

    assert_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        apply_inv && eff_all |=> hit_vec == '0);
endmodule

bind xlate_cache xl_tlb_checker #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .rs_valid(rs_valid), .rs_fault(rs_fault), .rs_hit(rs_hit),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .hit_vec(hit_vec), .fill_en(fill_en), .apply_inv(apply_inv), .eff_all(eff_all)
);

// File: tb/sim_xlate_cache.sv
module sim_xlate_cache;
    localparam logic [31:0] ROOT = 32'h0001_0000;
    localparam logic [19:0] SCR  = 20'hA5A5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0, lk_ready;
    logic [19:0] lk_vpn = '0;
    logic [7:0]  lk_asid = '0;
    logic        rs_valid, rs_fault, rs_hit;
    logic [19:0] rs_pfn;
    logic        inv_valid = 1'b0, inv_all = 1'b0;
    logic [19:0] inv_vpn = '0;
    logic [7:0]  inv_asid = '0;
    logic        mem_req_valid, mem_rsp_valid = 1'b0;
    logic [31:0] mem_req_addr, mem_rsp_data = '0;

    typedef struct {
        logic [19:0] pfn;
        logic        fault;
        logic        hit;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    int total = 0, failed = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    xlate_cache u0 (
        .clk(clk), .rst_n(rst_n), .root_base(ROOT),
        .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
        .rs_valid(rs_valid), .rs_pfn(rs_pfn), .rs_fault(rs_fault), .rs_hit(rs_hit),
        .inv_valid(inv_valid), .inv_all(inv_all), .inv_vpn(inv_vpn), .inv_asid(inv_asid),
        .mem_req_valid(mem_req_valid), .mem_req_ready(1'b1), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    endtask

    // Page-table model: word depends only on the address.
    function automatic logic [31:0] pt_word(logic [31:0] a);
        logic [9:0] idx, lo;
        if (a[31:24] == 8'h00) begin
            idx = 10'((a - ROOT) >> 2);
            return (idx == 10'h3FF) ? 32'h0 : {8'h40, 2'b00, idx, 12'h001};
        end else if (a[31:24] == 8'h40) begin
            idx = a[21:12];
            lo  = a[11:2];
            return {({idx, lo} ^ SCR), 11'h0, (lo[3:0] != 4'hF)};
        end
        return 32'hDEAD_BEE0;
    endfunction

    function automatic bit model_fault(logic [19:0] v);
        return (v[19:10] == 10'h3FF) || (v[3:0] == 4'hF);
    endfunction

    // Memory responder: answers in the cycle after acceptance.
    initial begin
        forever begin
            logic        took;
            logic [31:0] a;
            @(negedge clk);
            took = mem_req_valid;
            a    = mem_req_addr;
            @(posedge clk);
            #1;
            mem_rsp_valid = took;
            mem_rsp_data  = took ? pt_word(a) : 32'h0;
        end
    end

    // Monitor: compares each result with the scoreboard head.
    initial begin
        forever begin
            @(negedge clk);
            if (rs_valid) begin
                if (exp_q.size() == 0) begin
                    check("R1 unexpected result", 32'(rs_valid), 32'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check({e.tag, " hit flag"}, 32'(rs_hit), 32'(e.hit));
                    check({e.tag, " fault flag"}, 32'(rs_fault), 32'(e.fault));
                    if (!e.fault) check({e.tag, " frame"}, 32'(rs_pfn), 32'(e.pfn));
                end
            end
        end
    end

    task automatic look(logic [19:0] v, logic [7:0] id, bit exp_hit, string tag);
        exp_t e;
        e.pfn = v ^ SCR; e.fault = exp_hit ? 1'b0 : model_fault(v); e.hit = exp_hit; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        lk_valid = 1'b1; lk_vpn = v; lk_asid = id;
        while (!lk_ready) @(negedge clk);
        @(posedge clk);
        #1;
        lk_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic look_w(logic [19:0] v, logic [7:0] id, bit exp_hit, string tag);
        look(v, id, exp_hit, tag);
        drain();
    endtask

    task automatic inval(bit all, logic [19:0] v, logic [7:0] id);
        @(negedge clk);
        inv_valid = 1'b1; inv_all = all; inv_vpn = v; inv_asid = id;
        @(posedge clk);
        #1;
        inv_valid = 1'b0; inv_all = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; failed++;
        $display("FAIL R6 watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R6 reset ready", 32'(lk_ready), 32'h1);
        check("R1 reset result", 32'(rs_valid), 32'h0);
        check("R3 reset request", 32'(mem_req_valid), 32'h0);

        // R4 refill then R1 hit
        look_w(20'h00123, 8'd1, 0, "R4 refill");
        look_w(20'h00123, 8'd1, 1, "R1 hit");
        // R2 identifier match
        look_w(20'h00123, 8'd2, 0, "R2 other id misses");
        look_w(20'h00123, 8'd1, 1, "R2 first id kept");
        look_w(20'h00123, 8'd2, 1, "R2 second id hits");
        // R5 faults at both levels, never stored
        look_w(20'hFFC01, 8'd1, 0, "R5 level1 fault");
        look_w(20'hFFC01, 8'd1, 0, "R5 level1 fault again");
        look_w(20'h0012F, 8'd1, 0, "R5 level2 fault");
        look_w(20'h0012F, 8'd1, 0, "R5 level2 fault again");
        // R8 single invalidate
        inval(0, 20'h00123, 8'd2);
        look_w(20'h00123, 8'd1, 1, "R8 other id survives");
        look_w(20'h00123, 8'd2, 0, "R8 named entry cleared");
        // R7 clear-all
        inval(1, 20'h0, 8'd0);
        look_w(20'h00123, 8'd1, 0, "R7 clear-all");
        look_w(20'h00123, 8'd2, 0, "R7 clear-all second id");

        // R9 invalidate of the walked page during the walk; R6/R3 observed mid-walk
        look(20'h00456, 8'd1, 0, "R9 result despite invalidate");
        check("R6 ready low in walk", 32'(lk_ready), 32'h0);
        check("R3 level1 request", 32'(mem_req_valid), 32'h1);
        check("R3 level1 address", mem_req_addr, ROOT + 32'h4);
        inval(0, 20'h00456, 8'd1);
        drain();
        look_w(20'h00456, 8'd1, 0, "R9 fill discarded");
        // R9 invalidate of another page during a walk
        look(20'h00789, 8'd1, 0, "R9 walk with foreign invalidate");
        inval(0, 20'h00123, 8'd1);
        drain();
        look_w(20'h00789, 8'd1, 1, "R9 fill kept");
        look_w(20'h00123, 8'd1, 0, "R9 deferred invalidate applied");
        // R9 two invalidates during one walk -> clear-all
        look(20'h00AAA, 8'd1, 0, "R9 walk with two invalidates");
        inval(0, 20'h11111, 8'd1);
        inval(0, 20'h22222, 8'd1);
        drain();
        look_w(20'h00AAA, 8'd1, 0, "R9 merged clear-all drops fill");
        look_w(20'h00456, 8'd1, 0, "R9 merged clear-all clears old");

        // R10 replacement order
        inval(1, 20'h0, 8'd0);
        for (int k = 0; k < 8; k++) look_w(20'h01000 + 20'(k), 8'd1, 0, "R10 fill empty slot");
        for (int k = 0; k < 8; k++) look_w(20'h01000 + 20'(k), 8'd1, 1, "R10 all slots held");
        look_w(20'h01008, 8'd1, 0, "R10 first replacement");
        look_w(20'h01001, 8'd1, 1, "R10 slot1 untouched");
        look_w(20'h01000, 8'd1, 0, "R10 slot0 was replaced");
        look_w(20'h01001, 8'd1, 0, "R10 slot1 replaced second");
        look_w(20'h01003, 8'd1, 1, "R10 slot3 untouched");
        look_w(20'h01002, 8'd1, 0, "R10 slot2 replaced third");
        look_w(20'h01008, 8'd1, 1, "R10 newest kept");

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule